// File: doc/BRIEF.md
# Branch Condition Evaluator with Loop-End Term

This block produces the one-bit control-transfer condition for a bundle that carries a branch. A 4-bit condition-type code picks how the condition is formed: forced true, taken from one bit of a 32-entry predicate vector (plain or inverted), taken from a loop-end term, or a predicate merged with that loop-end term. The loop-end term comes from the loop status: the loop counter, the epilogue counter and a counter-valid flag.

The result is captured once per bundle when the bundle strobe is high, and it is held until the next strobe. A block-start pulse clears the result, so the first bundle of a new translation block never sees a stale condition. Two outputs go with the condition bit. One flags that the bundle is a conditional branch. The other reports the lock-based condition types, which this block does not evaluate.

Top module: `branch_cond_eval`

## Requirements
- R1: After synchronous reset, and in the cycle after a `blk_start` pulse, `take_branch`, `cond_branch` and `cond_unsup` are all 0.
- R2: When `bundle_en` is low, and neither `rst` nor `blk_start` is high, all three outputs keep their previous values, whatever the other inputs do.
- R3: The last-iteration term is 1 exactly when `loop_cnt` is below 2 as an unsigned number and `cnt_valid` is 1.
- R4: The loop-end term is last-iteration AND (`epi_cnt` == 0). Type 4 captures loop-end and type 5 captures its inverse.
- R5: Type 1 captures 1. Types 0, 10, 11, 12 and 13 capture 0.
- R6: The predicate bit used is `pred_vec[psrc[4:0]]`. Type 2 captures that bit and type 3 captures its inverse.
- R7: Type 6 captures predicate OR loop-end. Type 14 captures (NOT predicate) OR loop-end.
- R8: Type 15 captures predicate AND NOT loop-end. Type 7 captures (NOT predicate) AND NOT loop-end.
- R9: `cond_branch` captures 1 for every type of 2 or above and 0 for types 0 and 1.
- R10: Types 8 and 9 capture `cond_unsup` = 1 and `take_branch` = 0. Every other type captures `cond_unsup` = 0.
- R11: When `blk_start` and `bundle_en` are high in the same cycle, the clear wins and the outputs are 0 in the next cycle.
- R12: Each captured result appears on the outputs one clock edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_start | input | 1 | Translation-block start; clears the held result |
| bundle_en | input | 1 | Bundle strobe; captures a new result |
| ctype | input | 4 | Condition-type code |
| psrc | input | 5 | Predicate index into `pred_vec` |
| pred_vec | input | 32 | Predicate register file read value |
| loop_cnt | input | 32 | Loop counter |
| epi_cnt | input | 5 | Epilogue counter |
| cnt_valid | input | 1 | Loop counter valid flag |
| take_branch | output | 1 | Registered branch condition |
| cond_branch | output | 1 | Registered: bundle is a conditional branch |
| cond_unsup | output | 1 | Registered: condition type not supported |

## Verification
The assertions check on every cycle that the outputs hold without a strobe, that reset and block start clear them, that an unsupported type never takes the branch, and that the branch flag, the forced type and the pure loop-end type follow the inputs of the previous cycle. The predicate index decode, the merged predicate-and-loop-end types and the unsigned boundary of the loop counter can only be shown by the bench. Its scenarios sweep every predicate index, the counter values around 2 together with the largest count, nonzero epilogue counts and every type code. They compare all of these against a behavioural model.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int TYPE_W = 4;

  typedef enum logic [TYPE_W-1:0] {
    CT_NEVER          = 4'd0,
    CT_ALWAYS         = 4'd1,
    CT_PRED           = 4'd2,
    CT_NPRED          = 4'd3,
    CT_LEND           = 4'd4,
    CT_NLEND          = 4'd5,
    CT_PRED_OR_LE     = 4'd6,
    CT_NPRED_AND_NLE  = 4'd7,
    CT_LOCK_A         = 4'd8,
    CT_LOCK_B         = 4'd9,
    CT_NPRED_OR_LE    = 4'd14,
    CT_PRED_AND_NLE   = 4'd15
  } ctype_e;

  typedef struct packed {
    logic take;
    logic is_cond;
    logic unsup;
  } cond_res_t;

  localparam cond_res_t RES_CLEAR = '{take: 1'b0, is_cond: 1'b0, unsup: 1'b0};
endpackage

// File: rtl/bce_loop_end.sv
module bce_loop_end #(
  parameter int LCNT_W = 32,
  parameter int ECNT_W = 5
) (
  input  logic [LCNT_W-1:0] loop_cnt,
  input  logic [ECNT_W-1:0] epi_cnt,
  input  logic              cnt_valid,
  output logic              loop_end
);
  localparam logic [LCNT_W-1:0] LAST_LIMIT = LCNT_W'(2);

  logic last_iter;

  always_comb begin
    last_iter = (loop_cnt < LAST_LIMIT) && cnt_valid;
    loop_end  = last_iter && (epi_cnt == '0);
  end
endmodule

// File: rtl/bce_pred_select.sv
module bce_pred_select #(
  parameter int PRED_N = 32,
  parameter int PSRC_W = 5
) (
  input  logic [PRED_N-1:0] pred_vec,
  input  logic [PSRC_W-1:0] psrc,
  output logic              pred_bit
);
  localparam int IDX_W = $clog2(PRED_N);

  logic [IDX_W-1:0] idx;

  generate
    if (PSRC_W > IDX_W) begin : g_trim
      assign idx = psrc[IDX_W-1:0];
    end else begin : g_pad
      assign idx = IDX_W'(psrc);
    end
  endgenerate

  assign pred_bit = pred_vec[idx];
endmodule

// File: rtl/bce_cond_combine.sv
module bce_cond_combine
  import bce_pkg::*;
(
  input  logic [TYPE_W-1:0] ctype,
  input  logic              pred_bit,
  input  logic              loop_end,
  output cond_res_t         res
);
  logic base;

  always_comb begin
    base        = 1'b0;
    res         = RES_CLEAR;
    res.is_cond = (ctype >= TYPE_W'(2));
    case (ctype)
      CT_ALWAYS:        res.take = 1'b1;
      CT_PRED:          res.take = pred_bit;
      CT_NPRED:         res.take = ~pred_bit;
      CT_LEND:          res.take = loop_end;
      CT_NLEND:         res.take = ~loop_end;
      CT_PRED_OR_LE: begin
        base     = pred_bit;
        res.take = base | loop_end;
      end
      CT_NPRED_OR_LE: begin
        base     = ~pred_bit;
        res.take = base | loop_end;
      end
      CT_PRED_AND_NLE: begin
        base     = pred_bit;
        res.take = base & ~loop_end;
      end
      CT_NPRED_AND_NLE: begin
        base     = ~pred_bit;
        res.take = base & ~loop_end;
      end
      CT_LOCK_A, CT_LOCK_B: res.unsup = 1'b1;
      default:          res.take = 1'b0;
    endcase
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int PRED_N = 32,
  parameter int PSRC_W = 5,
  parameter int LCNT_W = 32,
  parameter int ECNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blk_start,
  input  logic              bundle_en,
  input  logic [3:0]        ctype,
  input  logic [PSRC_W-1:0] psrc,
  input  logic [PRED_N-1:0] pred_vec,
  input  logic [LCNT_W-1:0] loop_cnt,
  input  logic [ECNT_W-1:0] epi_cnt,
  input  logic              cnt_valid,
  output logic              take_branch,
  output logic              cond_branch,
  output logic              cond_unsup
);
  logic      pred_bit;
  logic      loop_end;
  cond_res_t res_next;
  cond_res_t res_q;

  bce_loop_end #(.LCNT_W(LCNT_W), .ECNT_W(ECNT_W)) u_loop_end (
    .loop_cnt (loop_cnt),
    .epi_cnt  (epi_cnt),
    .cnt_valid(cnt_valid),
    .loop_end (loop_end)
  );

  bce_pred_select #(.PRED_N(PRED_N), .PSRC_W(PSRC_W)) u_pred_sel (
    .pred_vec(pred_vec),
    .psrc    (psrc),
    .pred_bit(pred_bit)
  );

  bce_cond_combine u_combine (
    .ctype   (ctype),
    .pred_bit(pred_bit),
    .loop_end(loop_end),
    .res     (res_next)
  );

  always_ff @(posedge clk) begin
    if (rst || blk_start) begin
      res_q <= RES_CLEAR;
    end else if (bundle_en) begin
      res_q <= res_next;
    end
  end

  assign take_branch = res_q.take;
  assign cond_branch = res_q.is_cond;
  assign cond_unsup  = res_q.unsup;
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
  parameter int LCNT_W = 32,
  parameter int ECNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              blk_start,
  input logic              bundle_en,
  input logic [3:0]        ctype,
  input logic [LCNT_W-1:0] loop_cnt,
  input logic [ECNT_W-1:0] epi_cnt,
  input logic              cnt_valid,
  input logic              take_branch,
  input logic              cond_branch,
  input logic              cond_unsup
);
  logic cap;
  assign cap = bundle_en && !blk_start;

  // R1, R11: reset or block start leaves all outputs clear
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || $past(blk_start)) |-> (!take_branch && !cond_branch && !cond_unsup));

  // R2: no strobe, no change
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(blk_start) && !$past(bundle_en))
      |-> $stable({take_branch, cond_branch, cond_unsup}));

  // R4, R12: pure loop-end type
  assert_loopend_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap) && $past(ctype) == 4'd4)
      |-> take_branch == ($past(epi_cnt) == '0 && $past(loop_cnt) < LCNT_W'(2) && $past(cnt_valid)));

  // R5: forced type
  assert_always_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap) && $past(ctype) == 4'd1) |-> take_branch);

  // R9: conditional-branch flag
  assert_condflag_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cap)) |-> cond_branch == ($past(ctype) >= 4'd2));

  // R10: unsupported never takes the branch and is always a conditional type
  assert_unsup_R10: assert property (@(posedge clk) disable iff (rst)
    cond_unsup |-> (!take_branch && cond_branch));
endmodule

bind branch_cond_eval bce_checker #(.LCNT_W(LCNT_W), .ECNT_W(ECNT_W)) u_bce_chk (
  .clk        (clk),
  .rst        (rst),
  .blk_start  (blk_start),
  .bundle_en  (bundle_en),
  .ctype      (ctype),
  .loop_cnt   (loop_cnt),
  .epi_cnt    (epi_cnt),
  .cnt_valid  (cnt_valid),
  .take_branch(take_branch),
  .cond_branch(cond_branch),
  .cond_unsup (cond_unsup)
);

// File: tb/tb_branch_cond_eval.sv
`timescale 1ns/1ps
module tb_branch_cond_eval;
  logic        clk = 1'b0;
  logic        rst;
  logic        blk_start;
  logic        bundle_en;
  logic [3:0]  ctype;
  logic [4:0]  psrc;
  logic [31:0] pred_vec;
  logic [31:0] loop_cnt;
  logic [4:0]  epi_cnt;
  logic        cnt_valid;
  logic        take_branch, cond_branch, cond_unsup;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  string tag = "R1";

  bit m_take, m_br, m_err;

  always #10 clk = ~clk;

  branch_cond_eval dut (
    .clk(clk), .rst(rst), .blk_start(blk_start), .bundle_en(bundle_en),
    .ctype(ctype), .psrc(psrc), .pred_vec(pred_vec), .loop_cnt(loop_cnt),
    .epi_cnt(epi_cnt), .cnt_valid(cnt_valid),
    .take_branch(take_branch), .cond_branch(cond_branch), .cond_unsup(cond_unsup)
  );

  // behavioural reference
  function automatic bit ref_take(int t, bit p, longint lc, int ec, bit v);
    bit le;
    le = (lc < 2) && v && (ec == 0);
    case (t)
      1:  return 1'b1;
      2:  return p;
      3:  return !p;
      4:  return le;
      5:  return !le;
      6:  return p || le;
      14: return !p || le;
      15: return p && !le;
      7:  return !p && !le;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst || blk_start) begin
      m_take <= 1'b0; m_br <= 1'b0; m_err <= 1'b0;
    end else if (bundle_en) begin
      m_take <= ref_take(int'(ctype), pred_vec[psrc], longint'(loop_cnt), int'(epi_cnt), cnt_valid);
      m_br   <= (ctype >= 4'd2);
      m_err  <= (ctype == 4'd8) || (ctype == 4'd9);
    end
  end

  task automatic compare();
    vectors++;
    if ({take_branch, cond_branch, cond_unsup} !== {m_take, m_br, m_err}) begin
      miscompares++;
      $display("FAIL %s: got take=%b br=%b unsup=%b, expected take=%b br=%b unsup=%b (ctype=%0d psrc=%0d lcnt=%0h ecnt=%0d vld=%b)",
               tag, take_branch, cond_branch, cond_unsup, m_take, m_br, m_err,
               ctype, psrc, loop_cnt, epi_cnt, cnt_valid);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge (R12)
  task automatic step(input string t, input logic [3:0] ct, input logic [4:0] ps,
                      input logic [31:0] pv, input logic [31:0] lc,
                      input logic [4:0] ec, input logic vl,
                      input logic be, input logic bs);
    ctype = ct; psrc = ps; pred_vec = pv; loop_cnt = lc;
    epi_cnt = ec; cnt_valid = vl; bundle_en = be; blk_start = bs;
    tag = t;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcs [6];
    logic [31:0] pv;
    lcs[0] = 32'd0; lcs[1] = 32'd1; lcs[2] = 32'd2;
    lcs[3] = 32'd3; lcs[4] = 32'hFFFF_FFFF; lcs[5] = 32'h8000_0001;

    rst = 1'b1; blk_start = 1'b0; bundle_en = 1'b0; ctype = '0; psrc = '0;
    pred_vec = '0; loop_cnt = '0; epi_cnt = '0; cnt_valid = 1'b0;
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    // R1: reset holds outputs clear even with a strobe
    step("R1", 4'd1, 5'd0, '1, '0, '0, 1'b1, 1'b1, 1'b0);
    rst = 1'b0;

    // R5: forced and non-branch types
    step("R5", 4'd1, 5'd3, 32'h0, 32'd9, 5'd3, 1'b0, 1'b1, 1'b0);
    for (int t = 10; t <= 13; t++)
      step("R5", 4'(t), 5'd0, '1, '0, '0, 1'b1, 1'b1, 1'b0);
    step("R5", 4'd0, 5'd0, '1, '0, '0, 1'b1, 1'b1, 1'b0);

    // R1: block start clears a set result
    step("R1", 4'd1, 5'd0, '0, '0, '0, 1'b0, 1'b1, 1'b0);
    step("R1", 4'd2, 5'd0, '1, '0, '0, 1'b0, 1'b0, 1'b1);

    // R3, R4: loop-end boundaries via types 4 and 5
    for (int i = 0; i < 6; i++)
      for (int e = 0; e < 3; e++)
        for (int v = 0; v < 2; v++) begin
          step("R3", 4'd4, 5'd0, '0, lcs[i], (e == 2) ? 5'd31 : 5'(e), 1'(v), 1'b1, 1'b0);
          step("R4", 4'd5, 5'd0, '0, lcs[i], (e == 2) ? 5'd31 : 5'(e), 1'(v), 1'b1, 1'b0);
        end

    // R6: every predicate index, plain and inverted
    pv = 32'hA5C3_1E69;
    for (int k = 0; k < 32; k++) begin
      step("R6", 4'd2, 5'(k), pv, 32'd7, 5'd1, 1'b1, 1'b1, 1'b0);
      step("R6", 4'd3, 5'(k), pv, 32'd7, 5'd1, 1'b1, 1'b1, 1'b0);
    end

    // R7, R8: merged types across predicate and loop states
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 4; i++)
        for (int e = 0; e < 2; e++) begin
          step("R7", 4'd6,  5'd17, p ? 32'h0002_0000 : 32'hFFFD_FFFF, lcs[i], 5'(e), 1'b1, 1'b1, 1'b0);
          step("R7", 4'd14, 5'd17, p ? 32'h0002_0000 : 32'hFFFD_FFFF, lcs[i], 5'(e), 1'b1, 1'b1, 1'b0);
          step("R8", 4'd15, 5'd17, p ? 32'h0002_0000 : 32'hFFFD_FFFF, lcs[i], 5'(e), 1'b1, 1'b1, 1'b0);
          step("R8", 4'd7,  5'd17, p ? 32'h0002_0000 : 32'hFFFD_FFFF, lcs[i], 5'(e), 1'b1, 1'b1, 1'b0);
        end

    // R9: branch flag over every type code
    for (int t = 0; t < 16; t++)
      step("R9", 4'(t), 5'd5, 32'h0000_0020, 32'd0, 5'd0, 1'b1, 1'b1, 1'b0);

    // R10: unsupported lock types, with a true predicate and loop end
    step("R10", 4'd8, 5'd0, '1, 32'd0, 5'd0, 1'b1, 1'b1, 1'b0);
    step("R10", 4'd1, 5'd0, '1, 32'd0, 5'd0, 1'b1, 1'b1, 1'b0);
    step("R10", 4'd9, 5'd0, '1, 32'd0, 5'd0, 1'b1, 1'b1, 1'b0);

    // R2: no strobe, inputs wander, outputs hold
    step("R2", 4'd1, 5'd0, '0, '0, '0, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++)
      step("R2", 4'(k), 5'(k), $urandom, $urandom, 5'($urandom), 1'($urandom), 1'b0, 1'b0);

    // R11: clear beats a simultaneous strobe
    step("R11", 4'd1, 5'd0, '1, '0, '0, 1'b1, 1'b1, 1'b0);
    step("R11", 4'd1, 5'd0, '1, '0, '0, 1'b1, 1'b1, 1'b1);

    // R12: random mix, strobe and clear toggling, checked each cycle
    for (int k = 0; k < 300; k++)
      step("R12", 4'($urandom), 5'($urandom), $urandom,
           ($urandom % 4 == 0) ? 32'($urandom % 3) : $urandom,
           ($urandom % 2 == 0) ? 5'd0 : 5'($urandom), 1'($urandom),
           ($urandom % 4 != 0), ($urandom % 16 == 0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule